// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral driven through a small register interface. Once enabled it counts down in two stages on a prescaled tick. Expiry of the first stage may raise an interrupt, and expiry of the second stage drives a one-cycle reset pulse and sets a sticky timeout flag. After the second stage it begins the first stage again. Software keeps the system alive by restarting the countdown through a reload register, and every access to that register must be preceded by a two-write unlock sequence.

A lock bit, once written, keeps the watchdog running until the block's own reset input is asserted. The block's own reset pulse is meant to reset the rest of the system, not this block. The timeout flag therefore survives the system reset that the watchdog causes, and software can read it afterwards to learn why the system restarted.

Register map (word address on `reg_addr`): 0 = configuration, 1 = control, 2 = first-stage preload, 3 = second-stage preload, 4 = reload/status. Reads have one cycle of latency: `reg_rdata` holds the register addressed in the previous cycle.

Top module: `wdt2_top`

## Requirements
- R1: After `rst`, control and configuration read 0, both preloads read 0x3FF, the reload register reads 0, and `irq_o` and `wdt_rst_o` are low.
- R2: Control bit 1 is the run enable and bit 0 is the lock. Writing 0x02 starts the timer, writing 0x00 stops it while unlocked, and control reads back the stored bits.
- R3: Writing control with bit 0 set stores both lock and enable. Once locked, control writes are ignored and control reads 0x03 until `rst`.
- R4: With configuration bit 2 clear, the tick arrives every 2^15 clocks. With it set, the tick arrives every 2^5 clocks (fast test tick).
- R5: The first stage expires after P1 ticks. `irq_o` then pulses for one cycle, exactly 2^k·P1 clock edges after the edge that enabled or reloaded the timer (k = 15 or 5), unless configuration bits 1:0 are 11.
- R6: After the first stage expires, the second stage counts P2 ticks. On its expiry `wdt_rst_o` pulses for one cycle, unless configuration bit 5 is set. The first stage then starts again, so a second interrupt follows P1 ticks later.
- R7: Reload register bit 9 is a timeout flag. It is set when the second stage expires, even when the reset pulse is suppressed. It is cleared only by an accepted write with bit 9 set, or by `rst`.
- R8: A reload-register write is accepted only when the two writes immediately before it were 0x0080 and then 0x0086 to the reload register. One unlock admits one write, and a write to any other register breaks the sequence.
- R9: An accepted reload write with bit 8 set restarts the prescaler and the first stage.
- R10: Preloads are 10 bits wide and read back masked to 10 bits. A preload of 0 counts as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on/system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data of the previously addressed register |
| irq_o | output | 1 | One-cycle first-stage interrupt pulse |
| wdt_rst_o | output | 1 | One-cycle second-stage reset pulse |

## Verification
The assertions assume that `rst` is held high for at least two clock edges at start-up, so that their one-cycle look-back never sees pre-reset values. They also assume that the block's own reset pulse is never fed back into `rst`. The one-cycle pulse check relies on a tick period longer than one clock, which both prescaler settings guarantee. The stimulus meets these assumptions: it asserts `rst` for several cycles only at the start and before the final lock-release check, and it never connects `wdt_rst_o` to anything. It keeps preload values small and mostly uses the fast tick, so every expiry falls inside a bounded measurement window.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int ADR_CFG    = 0;
  localparam int ADR_CTRL   = 1;
  localparam int ADR_PRE1   = 2;
  localparam int ADR_PRE2   = 3;
  localparam int ADR_RELOAD = 4;

  localparam int CTRL_LOCK_BIT  = 0;
  localparam int CTRL_EN_BIT    = 1;
  localparam int CFG_FAST_BIT   = 2;
  localparam int CFG_RSTDIS_BIT = 5;
  localparam int RLD_BIT        = 8;
  localparam int TMO_BIT        = 9;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic {ST_FIRST, ST_SECOND} stage_e;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic fast,
  output logic tick
);
  localparam int CNT_W = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic             slow_wrap, fast_wrap;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign slow_wrap = &cnt_q[SLOW_LOG2-1:0];
  assign fast_wrap = &cnt_q[FAST_LOG2-1:0];
  assign tick      = run && !clear && (fast ? fast_wrap : slow_wrap);
endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown
  import wdt2_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic             expire1,
  output logic             expire2
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [1:0][PRE_W-1:0] pre_raw, pre_eff;
  stage_e                stage_q;
  logic [PRE_W-1:0]      cnt_q;
  logic                  last_tick;

  assign pre_raw[0] = pre1;
  assign pre_raw[1] = pre2;

  for (genvar g = 0; g < 2; g++) begin : g_sat
    assign pre_eff[g] = (pre_raw[g] == '0) ? ONE : pre_raw[g];
  end

  assign last_tick = run && !restart && tick && (cnt_q <= ONE);
  assign expire1   = last_tick && (stage_q == ST_FIRST);
  assign expire2   = last_tick && (stage_q == ST_SECOND);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      stage_q <= ST_FIRST;
      cnt_q   <= pre_eff[0];
    end else if (tick) begin
      if (cnt_q <= ONE) begin
        if (stage_q == ST_FIRST) begin
          stage_q <= ST_SECOND;
          cnt_q   <= pre_eff[1];
        end else begin
          stage_q <= ST_FIRST;
          cnt_q   <= pre_eff[0];
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 10,
  parameter int CFG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stage2_hit,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              en_q,
  output logic              lock_q,
  output logic [PRE_W-1:0]  pre1_q,
  output logic [PRE_W-1:0]  pre2_q,
  output logic              tmo_q,
  output logic              restart,
  output logic [DATA_W-1:0] rdata_q
);
  unlock_e     ul_q, ul_d;
  logic        wr_rld, accept;
  logic [DATA_W-1:0] rd_d;

  assign wr_rld  = wr && (addr == ADDR_W'(ADR_RELOAD));
  assign accept  = wr_rld && (ul_q == UL_OPEN);
  assign restart = accept && wdata[RLD_BIT];

  always_comb begin
    ul_d = ul_q;
    if (wr) begin
      if (!wr_rld) begin
        ul_d = UL_IDLE;
      end else begin
        case (ul_q)
          UL_IDLE: ul_d = (wdata == DATA_W'(KEY_FIRST)) ? UL_HALF : UL_IDLE;
          UL_HALF: begin
            if (wdata == DATA_W'(KEY_SECOND))     ul_d = UL_OPEN;
            else if (wdata == DATA_W'(KEY_FIRST)) ul_d = UL_HALF;
            else                                   ul_d = UL_IDLE;
          end
          default: ul_d = UL_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ul_q   <= UL_IDLE;
      cfg_q  <= '0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      pre1_q <= '1;
      pre2_q <= '1;
    end else begin
      ul_q <= ul_d;
      if (wr) begin
        case (addr)
          ADDR_W'(ADR_CFG):  cfg_q  <= wdata[CFG_W-1:0];
          ADDR_W'(ADR_PRE1): pre1_q <= wdata[PRE_W-1:0];
          ADDR_W'(ADR_PRE2): pre2_q <= wdata[PRE_W-1:0];
          ADDR_W'(ADR_CTRL): begin
            if (!lock_q) begin
              en_q   <= wdata[CTRL_EN_BIT] | wdata[CTRL_LOCK_BIT];
              lock_q <= wdata[CTRL_LOCK_BIT];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          tmo_q <= 1'b0;
    else if (stage2_hit)              tmo_q <= 1'b1;
    else if (accept && wdata[TMO_BIT]) tmo_q <= 1'b0;
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_W'(ADR_CFG):    rd_d[CFG_W-1:0] = cfg_q;
      ADDR_W'(ADR_CTRL):   begin
        rd_d[CTRL_EN_BIT]   = en_q;
        rd_d[CTRL_LOCK_BIT] = lock_q;
      end
      ADDR_W'(ADR_PRE1):   rd_d[PRE_W-1:0] = pre1_q;
      ADDR_W'(ADR_PRE2):   rd_d[PRE_W-1:0] = pre2_q;
      ADDR_W'(ADR_RELOAD): rd_d[TMO_BIT] = tmo_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int PRE_W     = 10,
  parameter int CFG_W     = 6,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             en_q, lock_q, tmo_q, restart, tick;
  logic [PRE_W-1:0] pre1_q, pre2_q;
  logic             expire1, expire2;

  wdt2_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .CFG_W(CFG_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .stage2_hit(expire2), .cfg_q(cfg_q), .en_q(en_q), .lock_q(lock_q),
    .pre1_q(pre1_q), .pre2_q(pre2_q), .tmo_q(tmo_q), .restart(restart),
    .rdata_q(reg_rdata)
  );

  wdt2_prescaler #(
    .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)
  ) u_pre (
    .clk(clk), .rst(rst), .run(en_q), .clear(restart),
    .fast(cfg_q[CFG_FAST_BIT]), .tick(tick)
  );

  wdt2_countdown #(.PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst(rst), .run(en_q), .restart(restart), .tick(tick),
    .pre1(pre1_q), .pre2(pre2_q), .expire1(expire1), .expire2(expire2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else begin
      irq_o     <= expire1 && (cfg_q[1:0] != 2'b11);
      wdt_rst_o <= expire2 && !cfg_q[CFG_RSTDIS_BIT];
    end
  end
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       lock,
  input logic       tmo,
  input logic [1:0] int_sel,
  input logic       rst_dis,
  input logic       irq,
  input logic       wrst
);
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    $past(lock) |-> lock);
  p_lock_keeps_en_r3: assert property (@(posedge clk) disable iff (rst)
    lock |-> en);
  p_no_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> !irq);
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    $past(int_sel == 2'b11) |-> !irq);
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_rst_masked_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst_dis) |-> !wrst);
  p_single_action_r6: assert property (@(posedge clk) disable iff (rst)
    !(irq && wrst));
  p_rst_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
    wrst |-> tmo);
endmodule

bind wdt2_top wdt2_checker u_chk (
  .clk(clk), .rst(rst), .en(en_q), .lock(lock_q), .tmo(tmo_q),
  .int_sel(cfg_q[1:0]), .rst_dis(cfg_q[5]), .irq(irq_o), .wrst(wdt_rst_o)
);

// File: tb/wdt2_top_test.sv
module wdt2_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int FAST = 32;
  localparam int SLOW = 32768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wrst;
  int          n_checks = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2_top uut (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  function automatic int exp_edges(int lim, int ticks);
    return lim * ((ticks == 0) ? 1 : ticks);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    wr = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic unlock_write(logic [15:0] d);
    wr_reg(3'd4, 16'h0080);
    wr_reg(3'd4, 16'h0086);
    wr_reg(3'd4, d);
  endtask

  // Count edges after the last write; record first/second irq and first reset pulse.
  task automatic measure(int maxk, output int k_irq1, output int k_irq2, output int k_rst);
    k_irq1 = -1; k_irq2 = -1; k_rst = -1;
    for (int k = 1; k <= maxk; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq) begin
        if (k_irq1 < 0) k_irq1 = k;
        else if (k_irq2 < 0) k_irq2 = k;
      end
      if (wrst && k_rst < 0) k_rst = k;
    end
  endtask

  task automatic make_flag();
    int a, b, c;
    wr_reg(3'd1, 16'h0000);
    wr_reg(3'd2, 16'd1);
    wr_reg(3'd3, 16'd1);
    wr_reg(3'd0, 16'h0004);
    wr_reg(3'd1, 16'h0002);
    measure(2 * FAST + 4, a, b, c);
    wr_reg(3'd1, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int ki1, ki2, kr;
    void'($urandom(32'h5eed1234));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 wdt_rst", wrst, 0);
    rd_reg(3'd1, v); check("R1 ctrl", v, 0);
    rd_reg(3'd0, v); check("R1 cfg", v, 0);
    rd_reg(3'd2, v); check("R1 pre1", v, 16'h03FF);
    rd_reg(3'd3, v); check("R1 pre2", v, 16'h03FF);
    rd_reg(3'd4, v); check("R1 reload", v, 0);

    // R2 enable/stop readback
    wr_reg(3'd1, 16'h0002); rd_reg(3'd1, v); check("R2 enable read", v, 2);
    wr_reg(3'd1, 16'h0000); rd_reg(3'd1, v); check("R2 stop read", v, 0);

    // R10 preload masking and zero preload
    wr_reg(3'd2, 16'hFFFF); rd_reg(3'd2, v); check("R10 pre1 mask", v, 16'h03FF);
    wr_reg(3'd2, 16'h0000);
    wr_reg(3'd3, 16'd50);
    wr_reg(3'd0, 16'h0024);
    wr_reg(3'd1, 16'h0002);
    measure(FAST + 4, ki1, ki2, kr);
    check("R10 zero preload irq edge", ki1, exp_edges(FAST, 0));
    wr_reg(3'd1, 16'h0000);

    // R5 R6 R7 random two-stage runs (fast tick)
    for (int it = 0; it < 6; it++) begin
      int p1, p2, ioff, roff;
      int e_i1, e_i2, e_r;
      p1 = 1 + int'($urandom % 5);
      p2 = 1 + int'($urandom % 5);
      ioff = int'($urandom % 2);
      roff = int'($urandom % 2);
      wr_reg(3'd1, 16'h0000);
      wr_reg(3'd2, 16'(p1));
      wr_reg(3'd3, 16'(p2));
      wr_reg(3'd0, 16'h0004 | (ioff != 0 ? 16'h0003 : 16'h0) | (roff != 0 ? 16'h0020 : 16'h0));
      wr_reg(3'd1, 16'h0002);
      measure(FAST * (2 * p1 + p2) + 4, ki1, ki2, kr);
      e_i1 = (ioff != 0) ? -1 : exp_edges(FAST, p1);
      e_i2 = (ioff != 0) ? -1 : exp_edges(FAST, 2 * p1 + p2);
      e_r  = (roff != 0) ? -1 : exp_edges(FAST, p1 + p2);
      check("R5 first irq edge", ki1, e_i1);
      check("R6 reset pulse edge", kr, e_r);
      check("R6 restart second irq edge", ki2, e_i2);
      wr_reg(3'd1, 16'h0000);
      rd_reg(3'd4, v); check("R7 flag set", v, 16'h0200);
      unlock_write(16'h0200);
      rd_reg(3'd4, v); check("R7 flag cleared", v, 0);
    end

    // R8 unlock sequence rules
    make_flag();
    rd_reg(3'd4, v); check("R8 flag precondition", v, 16'h0200);
    wr_reg(3'd4, 16'h0200);
    rd_reg(3'd4, v); check("R8 write without unlock ignored", v, 16'h0200);
    wr_reg(3'd4, 16'h0080); wr_reg(3'd0, 16'h0004); wr_reg(3'd4, 16'h0086); wr_reg(3'd4, 16'h0200);
    rd_reg(3'd4, v); check("R8 broken sequence ignored", v, 16'h0200);
    unlock_write(16'h0000);
    wr_reg(3'd4, 16'h0200);
    rd_reg(3'd4, v); check("R8 one write per unlock", v, 16'h0200);
    unlock_write(16'h0200);
    rd_reg(3'd4, v); check("R8 proper unlock clears", v, 0);

    // R9 reload restarts the countdown
    wr_reg(3'd2, 16'd4);
    wr_reg(3'd3, 16'd8);
    wr_reg(3'd0, 16'h0004);
    wr_reg(3'd1, 16'h0002);
    measure(100, ki1, ki2, kr);
    check("R9 no irq before reload", ki1, -1);
    unlock_write(16'h0100);
    measure(exp_edges(FAST, 4) + 2, ki1, ki2, kr);
    check("R9 irq after reload", ki1, exp_edges(FAST, 4));
    wr_reg(3'd1, 16'h0000);

    // R4 slow tick
    wr_reg(3'd2, 16'd1);
    wr_reg(3'd3, 16'd8);
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd1, 16'h0002);
    measure(SLOW + 4, ki1, ki2, kr);
    check("R4 slow tick irq edge", ki1, SLOW);
    wr_reg(3'd1, 16'h0000);

    // R3 lock
    wr_reg(3'd1, 16'h0001);
    rd_reg(3'd1, v); check("R3 lock sets enable", v, 3);
    wr_reg(3'd1, 16'h0000);
    rd_reg(3'd1, v); check("R3 locked stop ignored", v, 3);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    rd_reg(3'd1, v); check("R3 reset releases lock", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule